// File: doc/BRIEF.md
# Read-Armed Hardware Option Latch

The block holds the chip's hardware option settings. The option values live as code bytes in a 36-byte window of program storage, from 24'h00FFA0 to 24'h00FFC3. A stored value has no effect until the CPU reads that exact location after a reset. The latch watches the system bus. When it sees a qualified read of an option address, it copies the returned byte into the matching option fields. Every reset clears all armed options back to their defaults, so boot code must read the window again after each reset.

The captured bytes drive four groups of outputs:
- a clock divider select for each peripheral (fosc divided by 2^0 to 2^7);
- a source select for six interrupt inputs;
- a slow or fast edge mode for each universal port pin;
- receive and transmit polarity bits for five serial units.

The latch also drives the watchdog and clock-monitor enables and four general option bytes. Eight addresses in the middle of the window are fixed at build time. Bus reads of those addresses are ignored.

Top module: `hw_option_latch`

## Requirements
- R1: While rst_n is low (asynchronous, active low), and right after it is released:
  - every clock select is 0 and every interrupt select is 0;
  - both polarity vectors are 0, and wdog_en, clkmon_en and gen_opt are 0;
  - opt_armed is all zero;
  - port_fast is 56'h0F, so pins 0..3 of the first port are fast and every other pin is slow.
- R2: A capture happens when, on a rising clock edge, bus_valid=1, bus_write=0 and bus_addr equals a programmable window address. The byte on bus_rdata then appears on the matching fields and sets the matching opt_armed bit (bit = address − 24'h00FFA0) by the next falling edge. With bus_valid=0 nothing changes.
- R3: A cycle with bus_write=1 changes no output, even when the address is inside the window.
- R4: A read whose full 24-bit address lies outside 24'h00FFA0..24'h00FFC3 changes no output. This includes addresses that differ only in the upper byte.
- R5: Reads of 24'h00FFB8..24'h00FFBF change no output and leave those opt_armed bits at 0. fixed_opt always equals the build parameter, whose default is 64'hC3A5_0F0F_F0F0_5A3C.
- R6: The byte at 24'h00FFA0+k (k = 0..7) sets clock select 2k from bits [2:0] and clock select 2k+1 from bits [6:4]. Bits 3 and 7 are ignored. Clock select m sits at clk_div_sel[3m+2:3m], and its value n means fosc divided by 2^n.
- R7: Bits [1:0] of the bytes at 24'h00FFA8..24'h00FFAD set the source selects of interrupt inputs 5, 6, 7, 13, 14 and 15, in that order, at irq_src_sel[2i+1:2i].
- R8: The byte at 24'h00FFAE+p (p = 0..6) sets port_fast[8p+7:8p]. Bit n of that byte is pin n of port p, and 1 means fast.
- R9: The byte at 24'h00FFB5 sets ser_rx_inv from bits [4:0], and the byte at 24'h00FFB6 sets ser_tx_inv from bits [4:0]. The byte at 24'h00FFB7 sets wdog_en from bit 0 and clkmon_en from bit 1.
- R10: The bytes at 24'h00FFC0..24'h00FFC3 fill gen_opt in byte order, with the lowest address going to bits [7:0].
- R11: An opt_armed bit never clears except on reset. A later read of the same address replaces the earlier value. After a new reset, an option is back at its default until it is read again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_valid | input | 1 | Bus transfer strobe; data is valid in this cycle |
| bus_write | input | 1 | 1 = write transfer, 0 = read transfer |
| bus_addr | input | 24 | Byte address of the transfer |
| bus_rdata | input | 8 | Data returned on a read |
| clk_div_sel | output | 48 | Sixteen 3-bit divider selects |
| irq_src_sel | output | 12 | Six 2-bit interrupt source selects |
| port_fast | output | 56 | Per-pin edge mode, 1 = fast |
| ser_rx_inv | output | 5 | Receive polarity per serial unit |
| ser_tx_inv | output | 5 | Transmit polarity per serial unit |
| wdog_en | output | 1 | Watchdog enabled by option |
| clkmon_en | output | 1 | Clock monitor enabled by option |
| gen_opt | output | 32 | General option bytes |
| fixed_opt | output | 64 | Build-time option bytes |
| opt_armed | output | 36 | Per-address armed flag |

## Verification
The bound checker watches four rules on every cycle:
- writes, out-of-window reads and reads of the fixed range leave all option outputs and armed flags unchanged;
- an armed flag never drops between resets;
- a read of the first address arms it, and a read of the safety byte loads the watchdog enable;
- the state is clear right after reset.

Only the bench's scenarios can show the bit layouts of the clock, interrupt, port, polarity and general fields against chosen bytes. The same holds for the non-uniform port default, last-read-wins overwrites, and the loss of all armed options when reset is applied again.

// File: rtl/opt_pkg.sv
package opt_pkg;
    localparam int OPT_BYTES  = 36;
    localparam int CLK_MODS   = 16;
    localparam int CLK_SEL_W  = 3;
    localparam int IRQ_LINES  = 6;
    localparam int IRQ_SEL_W  = 2;
    localparam int PORT_COUNT = 7;
    localparam int PORT_PINS  = 8;
    localparam int SER_UNITS  = 5;
    localparam int GEN_BYTES  = 4;
    localparam int FIX_LO     = 24;
    localparam int FIX_HI     = 31;

    localparam int OFS_CLK   = 0;
    localparam int OFS_IRQ   = OFS_CLK + CLK_MODS / 2;
    localparam int OFS_PORT  = OFS_IRQ + IRQ_LINES;
    localparam int OFS_RXINV = OFS_PORT + PORT_COUNT;
    localparam int OFS_TXINV = OFS_RXINV + 1;
    localparam int OFS_SAFE  = OFS_TXINV + 1;
    localparam int OFS_GEN   = FIX_HI + 1;

    localparam int FIX_BITS  = (FIX_HI - FIX_LO + 1) * 8;
    localparam int PORT_BITS = PORT_COUNT * PORT_PINS;
    localparam int OUT_BITS  = CLK_MODS * CLK_SEL_W + IRQ_LINES * IRQ_SEL_W
                             + PORT_BITS + 2 * SER_UNITS + 2 + GEN_BYTES * 8;

    localparam logic [PORT_BITS-1:0] PORT_FAST_RST = PORT_BITS'('h0F);

    typedef struct packed {
        logic [CLK_MODS-1:0][CLK_SEL_W-1:0]  clk_div;
        logic [IRQ_LINES-1:0][IRQ_SEL_W-1:0] irq_src;
        logic [PORT_BITS-1:0]                port_fast;
        logic [SER_UNITS-1:0]                rx_inv;
        logic [SER_UNITS-1:0]                tx_inv;
        logic                                wdog_en;
        logic                                clkmon_en;
        logic [GEN_BYTES*8-1:0]              gen;
        logic [OPT_BYTES-1:0]                armed;
    } opt_state_t;

    function automatic opt_state_t opt_rst_state();
        opt_state_t s;
        s = '0;
        s.port_fast = PORT_FAST_RST;
        return s;
    endfunction
endpackage

// File: rtl/opt_win_decode.sv
module opt_win_decode
    import opt_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'h00FFA0
) (
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    output logic [OPT_BYTES-1:0] cap_en
);
    logic rd_qual;
    assign rd_qual = bus_valid && !bus_write;

    for (genvar i = 0; i < OPT_BYTES; i++) begin : g_sel
        if (i >= FIX_LO && i <= FIX_HI) begin : g_fixed
            assign cap_en[i] = 1'b0;
        end else begin : g_prog
            assign cap_en[i] = rd_qual && (bus_addr == WIN_BASE + ADDR_W'(i));
        end
    end
endmodule

// File: rtl/opt_field_store.sv
module opt_field_store
    import opt_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [OPT_BYTES-1:0] cap_en,
    input  logic [7:0]           rdata,
    output opt_state_t           st
);
    localparam opt_state_t ST_RST = opt_rst_state();

    opt_state_t st_d, st_q;

    always_comb begin
        st_d       = st_q;
        st_d.armed = st_q.armed | cap_en;
        for (int k = 0; k < CLK_MODS / 2; k++) begin
            if (cap_en[OFS_CLK + k]) begin
                st_d.clk_div[2*k]   = rdata[CLK_SEL_W-1:0];
                st_d.clk_div[2*k+1] = rdata[4 +: CLK_SEL_W];
            end
        end
        for (int i = 0; i < IRQ_LINES; i++) begin
            if (cap_en[OFS_IRQ + i]) st_d.irq_src[i] = rdata[IRQ_SEL_W-1:0];
        end
        for (int p = 0; p < PORT_COUNT; p++) begin
            if (cap_en[OFS_PORT + p]) st_d.port_fast[p*PORT_PINS +: PORT_PINS] = rdata[PORT_PINS-1:0];
        end
        if (cap_en[OFS_RXINV]) st_d.rx_inv = rdata[SER_UNITS-1:0];
        if (cap_en[OFS_TXINV]) st_d.tx_inv = rdata[SER_UNITS-1:0];
        if (cap_en[OFS_SAFE]) begin
            st_d.wdog_en   = rdata[0];
            st_d.clkmon_en = rdata[1];
        end
        for (int g = 0; g < GEN_BYTES; g++) begin
            if (cap_en[OFS_GEN + g]) st_d.gen[g*8 +: 8] = rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_RST;
        else        st_q <= st_d;
    end

    assign st = st_q;
endmodule

// File: rtl/hw_option_latch.sv
module hw_option_latch
    import opt_pkg::*;
#(
    parameter int                  ADDR_W    = 24,
    parameter logic [ADDR_W-1:0]   WIN_BASE  = 24'h00FFA0,
    parameter logic [FIX_BITS-1:0] FIXED_VAL = 64'hC3A5_0F0F_F0F0_5A3C
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              bus_valid,
    input  logic                              bus_write,
    input  logic [ADDR_W-1:0]                 bus_addr,
    input  logic [7:0]                        bus_rdata,
    output logic [CLK_MODS*CLK_SEL_W-1:0]     clk_div_sel,
    output logic [IRQ_LINES*IRQ_SEL_W-1:0]    irq_src_sel,
    output logic [PORT_BITS-1:0]              port_fast,
    output logic [SER_UNITS-1:0]              ser_rx_inv,
    output logic [SER_UNITS-1:0]              ser_tx_inv,
    output logic                              wdog_en,
    output logic                              clkmon_en,
    output logic [GEN_BYTES*8-1:0]            gen_opt,
    output logic [FIX_BITS-1:0]               fixed_opt,
    output logic [OPT_BYTES-1:0]              opt_armed
);
    logic [OPT_BYTES-1:0] cap_en;
    opt_state_t           st;

    opt_win_decode #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_decode (
        .bus_valid (bus_valid),
        .bus_write (bus_write),
        .bus_addr  (bus_addr),
        .cap_en    (cap_en)
    );

    opt_field_store u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_en (cap_en),
        .rdata  (bus_rdata),
        .st     (st)
    );

    assign clk_div_sel = st.clk_div;
    assign irq_src_sel = st.irq_src;
    assign port_fast   = st.port_fast;
    assign ser_rx_inv  = st.rx_inv;
    assign ser_tx_inv  = st.tx_inv;
    assign wdog_en     = st.wdog_en;
    assign clkmon_en   = st.clkmon_en;
    assign gen_opt     = st.gen;
    assign fixed_opt   = FIXED_VAL;
    assign opt_armed   = st.armed;
endmodule

// File: rtl/hw_option_latch_chk.sv
module hw_option_latch_chk
    import opt_pkg::*;
#(
    parameter int                ADDR_W   = 24,
    parameter logic [ADDR_W-1:0] WIN_BASE = 24'h00FFA0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_valid,
    input logic                 bus_write,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic [7:0]           bus_rdata,
    input logic [OUT_BITS-1:0]  outs,
    input logic                 wdog_en,
    input logic [OPT_BYTES-1:0] opt_armed
);
    logic rd_q, out_win, in_fix;
    assign rd_q    = bus_valid && !bus_write;
    assign out_win = (bus_addr < WIN_BASE) || (bus_addr >= WIN_BASE + ADDR_W'(OPT_BYTES));
    assign in_fix  = (bus_addr >= WIN_BASE + ADDR_W'(FIX_LO)) && (bus_addr <= WIN_BASE + ADDR_W'(FIX_HI));

    // R1: state is clear on the first edge after reset release
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (opt_armed == '0 && !wdog_en));

    // R2: read of first window address arms its flag
    a_r2_read_arms: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && bus_addr == WIN_BASE) |=> opt_armed[0]);

    // R3: writes leave everything unchanged
    a_r3_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid && bus_write) |=> ($stable(outs) && $stable(opt_armed)));

    // R4: reads outside the window leave everything unchanged
    a_r4_outside_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && out_win) |=> ($stable(outs) && $stable(opt_armed)));

    // R5: reads of the fixed range leave everything unchanged
    a_r5_fixed_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && in_fix) |=> ($stable(outs) && $stable(opt_armed)));

    // R9: safety byte loads the watchdog enable
    a_r9_wdog_load: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_q && bus_addr == WIN_BASE + ADDR_W'(OFS_SAFE)) |=> (wdog_en == $past(bus_rdata[0])));

    // R11: armed flags are sticky until reset
    a_r11_armed_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ((opt_armed & $past(opt_armed)) == $past(opt_armed)));
endmodule

bind hw_option_latch hw_option_latch_chk #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_valid (bus_valid),
    .bus_write (bus_write),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .outs      ({clk_div_sel, irq_src_sel, port_fast, ser_rx_inv, ser_tx_inv, wdog_en, clkmon_en, gen_opt}),
    .wdog_en   (wdog_en),
    .opt_armed (opt_armed)
);

// File: tb/hw_option_latch_bench.sv
module hw_option_latch_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [23:0] bus_addr = '0;
    logic [7:0]  bus_rdata = '0;

    logic [47:0] clk_div_sel;
    logic [11:0] irq_src_sel;
    logic [55:0] port_fast;
    logic [4:0]  ser_rx_inv, ser_tx_inv;
    logic        wdog_en, clkmon_en;
    logic [31:0] gen_opt;
    logic [63:0] fixed_opt;
    logic [35:0] opt_armed;

    hw_option_latch u_hw_option_latch (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_rdata(bus_rdata), .clk_div_sel(clk_div_sel),
        .irq_src_sel(irq_src_sel), .port_fast(port_fast), .ser_rx_inv(ser_rx_inv),
        .ser_tx_inv(ser_tx_inv), .wdog_en(wdog_en), .clkmon_en(clkmon_en),
        .gen_opt(gen_opt), .fixed_opt(fixed_opt), .opt_armed(opt_armed)
    );

    always #2 clk = ~clk;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [47:0] e_clk;
    logic [11:0] e_irq;
    logic [55:0] e_fast;
    logic [4:0]  e_rx, e_tx;
    logic        e_wd, e_cm;
    logic [31:0] e_gen;
    logic [35:0] e_arm;

    // {tag, write, addr, data}
    localparam int NV = 19;
    localparam logic [40:0] VECS [NV] = '{
        {8'd6,  1'b0, 24'h00FFA0, 8'hB5},   // R6 low/high selects, bit 7 dropped
        {8'd6,  1'b0, 24'h00FFA7, 8'h72},   // R6 last clock byte
        {8'd7,  1'b0, 24'h00FFA8, 8'hFD},   // R7 first interrupt select
        {8'd7,  1'b0, 24'h00FFAD, 8'h02},   // R7 last interrupt select
        {8'd8,  1'b0, 24'h00FFAE, 8'hF0},   // R8 overrides first-port default
        {8'd8,  1'b0, 24'h00FFB4, 8'h81},   // R8 last port
        {8'd9,  1'b0, 24'h00FFB5, 8'h15},   // R9 rx polarity
        {8'd9,  1'b0, 24'h00FFB6, 8'hEA},   // R9 tx polarity
        {8'd9,  1'b0, 24'h00FFB7, 8'h03},   // R9 watchdog and clock monitor
        {8'd10, 1'b0, 24'h00FFC0, 8'h11},   // R10 lowest general byte
        {8'd10, 1'b0, 24'h00FFC3, 8'hEE},   // R10 highest general byte
        {8'd3,  1'b1, 24'h00FFA1, 8'h77},   // R3 write in window
        {8'd4,  1'b0, 24'h00FF9F, 8'h55},   // R4 just below
        {8'd4,  1'b0, 24'h00FFC4, 8'h55},   // R4 just above
        {8'd4,  1'b0, 24'h01FFA2, 8'h55},   // R4 upper-byte alias
        {8'd5,  1'b0, 24'h00FFB8, 8'hFF},   // R5 first fixed address
        {8'd5,  1'b0, 24'h00FFBF, 8'hFF},   // R5 last fixed address
        {8'd11, 1'b0, 24'h00FFA0, 8'h01},   // R11 re-read replaces value
        {8'd2,  1'b0, 24'h00FFA3, 8'h24}    // R2 plain capture
    };

    task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic model_reset();
        e_clk = '0; e_irq = '0; e_fast = 56'h0F; e_rx = '0; e_tx = '0;
        e_wd = 1'b0; e_cm = 1'b0; e_gen = '0; e_arm = '0;
    endtask

    task automatic model_apply(logic wr, logic [23:0] a, logic [7:0] d);
        int off;
        if (wr) return;
        if (a < 24'h00FFA0 || a > 24'h00FFC3) return;
        off = int'(a - 24'h00FFA0);
        if (off >= 24 && off <= 31) return;
        e_arm[off] = 1'b1;
        if (off < 8) begin
            e_clk[off*6 +: 3]     = d[2:0];
            e_clk[off*6 + 3 +: 3] = d[6:4];
        end else if (off < 14) e_irq[(off-8)*2 +: 2] = d[1:0];
        else if (off < 21)     e_fast[(off-14)*8 +: 8] = d;
        else if (off == 21)    e_rx = d[4:0];
        else if (off == 22)    e_tx = d[4:0];
        else if (off == 23)    begin e_wd = d[0]; e_cm = d[1]; end
        else                   e_gen[(off-32)*8 +: 8] = d;
    endtask

    task automatic compare_all(string tag);
        check(tag, "clk_div_sel", 64'(clk_div_sel), 64'(e_clk));
        check(tag, "irq_src_sel", 64'(irq_src_sel), 64'(e_irq));
        check(tag, "port_fast",   64'(port_fast),   64'(e_fast));
        check(tag, "ser_rx_inv",  64'(ser_rx_inv),  64'(e_rx));
        check(tag, "ser_tx_inv",  64'(ser_tx_inv),  64'(e_tx));
        check(tag, "wdog_en",     64'(wdog_en),     64'(e_wd));
        check(tag, "clkmon_en",   64'(clkmon_en),   64'(e_cm));
        check(tag, "gen_opt",     64'(gen_opt),     64'(e_gen));
        check(tag, "opt_armed",   64'(opt_armed),   64'(e_arm));
    endtask

    task automatic bus_cycle(logic wr, logic [23:0] a, logic [7:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_rdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        model_apply(wr, a, d);
    endtask

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        compare_all("R1");              // R1 during reset
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R1");              // R1 after release
        check("R5", "fixed_opt", fixed_opt, 64'hC3A5_0F0F_F0F0_5A3C);

        for (int v = 0; v < NV; v++) begin
            bus_cycle(VECS[v][32], VECS[v][31:8], VECS[v][7:0]);
            compare_all($sformatf("R%0d", int'(VECS[v][40:33])));
        end
        check("R5", "fixed_opt", fixed_opt, 64'hC3A5_0F0F_F0F0_5A3C);

        // R2: window address with strobe low does nothing
        @(negedge clk);
        bus_valid = 1'b0; bus_addr = 24'h00FFA5; bus_rdata = 8'h66;
        @(negedge clk);
        compare_all("R2");

        // R11: a new reset drops every armed option
        rst_n = 1'b0;
        model_reset();
        @(negedge clk);
        compare_all("R11");
        rst_n = 1'b1;
        @(negedge clk);
        compare_all("R11");
        bus_cycle(1'b0, 24'h00FFB7, 8'h02);
        compare_all("R11");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule